// File: doc/BRIEF.md
# Fast Ethernet Transmit Line Encoder

This block turns a transmit nibble stream from a MAC into the three-level line signal used by 100 Mb/s twisted-pair Ethernet. The block runs on one 125 MHz bit clock. Every fifth cycle it takes one 4-bit nibble together with its transmit-enable and tells the MAC which cycle that is through `nib_take`. It replaces each nibble with a 5-bit code group and marks the start and end of each frame with delimiter pairs. When no frame is being sent it fills the gaps with idle groups. It shifts the groups out most significant bit first and whitens the serial stream with a free-running scrambler. It then drives the line as MLT-3, with the three levels carried on two bits.

The framing is a four-state machine that advances once per symbol slot:
- `FR_IDLE` emits idle (11111). When transmit-enable is seen it emits J and moves to `FR_SSD2`.
- `FR_SSD2` emits K and always moves to `FR_DATA`.
- `FR_DATA` emits the data group of the nibble while enable stays high. When enable drops it emits T and moves to `FR_ESD2`.
- `FR_ESD2` emits R and returns to `FR_IDLE`.

The MLT-3 stage is a second four-state ring: `LV_ZUP` (0, next +1), `LV_POS` (+1), `LV_ZDN` (0, next -1) and `LV_NEG` (-1). It moves one step on each scrambled one and holds its state on a zero. The frame checksum is produced upstream and passes through as ordinary data.

Top module: `fx_line_enc`

## Requirements
- R1: While `rst_n` is low, `line_pos`, `line_neg` and `nib_take` are all 0. After reset the line carries scrambled idle.
- R2: While `tx_en` stays low, every code group on the line, after descrambling, is idle (11111).
- R3: A frame starts with J (11000) followed by K (10001). These two groups replace the first two nibbles accepted with `tx_en` high.
- R4: Each later nibble accepted with `tx_en` high is sent as its 5-bit group, most significant bit first. The mapping is 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R5: The first nibble slot with `tx_en` low after data emits T (01101). The next slot emits R (00111), and idle or a new J follows.
- R6: `nib_take` is high for exactly one cycle in every five. `tx_en` and `txd` are sampled at the clock edge that ends that cycle.
- R7: Each line bit is the plain bit XOR a key. The key is bit 10 XOR bit 8 of an 11-bit register (x^11 + x^9 + 1). The register shifts the key into bit 0 every cycle and is reset to a nonzero seed. The descrambled idle therefore stays all ones while the raw line keeps toggling.
- R8: The line level changes only after a scrambled one bit, in the order 0, +1, 0, -1. It never jumps directly between +1 and -1.
- R9: `line_pos` and `line_neg` are never high together. +1 is pos=1, -1 is neg=1, and 0 is both low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 125 MHz bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Frame-active flag for the nibble being offered |
| txd | input | 4 | Transmit nibble |
| nib_take | output | 1 | High in the cycle whose closing edge samples `tx_en`/`txd` |
| line_pos | output | 1 | Line is at the +1 level |
| line_neg | output | 1 | Line is at the -1 level |

## Verification
The checker watches the two level bits every cycle:
- it rejects any cycle where both are high;
- it rejects any direct jump between +1 and -1;
- it rejects two nonzero excursions of the same sign in a row;
- it requires the five-cycle spacing of `nib_take`;
- it requires the ordered delimiter pairs J→K and T→R, and idle or J after R.

Recovering the frame content needs more than single-cycle checks, so only the bench scenarios can show it. The bench descrambles the line, aligns on J/K and decodes the 5-bit groups. This shows that idle gaps descramble to all ones, that every payload nibble, including all sixteen values, comes back in order, and that a frame with no payload closes correctly.

// File: rtl/fx_line_pkg.sv
package fx_line_pkg;

    localparam int SYM_W = 5;
    localparam int NIB_W = 4;

    typedef logic [SYM_W-1:0] sym_t;

    localparam sym_t SYM_IDLE = 5'b11111;
    localparam sym_t SYM_J    = 5'b11000;
    localparam sym_t SYM_K    = 5'b10001;
    localparam sym_t SYM_T    = 5'b01101;
    localparam sym_t SYM_R    = 5'b00111;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_SSD2,
        FR_DATA,
        FR_ESD2
    } frame_st_t;

    typedef enum logic [1:0] {
        LV_ZUP,
        LV_POS,
        LV_ZDN,
        LV_NEG
    } lvl_st_t;

    function automatic sym_t enc_nib(input logic [NIB_W-1:0] n);
        case (n)
            4'h0: return 5'b11110;
            4'h1: return 5'b01001;
            4'h2: return 5'b10100;
            4'h3: return 5'b10101;
            4'h4: return 5'b01010;
            4'h5: return 5'b01011;
            4'h6: return 5'b01110;
            4'h7: return 5'b01111;
            4'h8: return 5'b10010;
            4'h9: return 5'b10011;
            4'hA: return 5'b10110;
            4'hB: return 5'b10111;
            4'hC: return 5'b11010;
            4'hD: return 5'b11011;
            4'hE: return 5'b11100;
            4'hF: return 5'b11101;
        endcase
    endfunction

endpackage

// File: rtl/fx_sym_fsm.sv
module fx_sym_fsm
    import fx_line_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot,
    input  logic             tx_en,
    input  logic [NIB_W-1:0] txd,
    output sym_t             code
);

    frame_st_t state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= FR_IDLE;
        else if (slot)
            state <= nxt;
    end

    always_comb begin
        nxt  = state;
        code = SYM_IDLE;
        unique case (state)
            FR_IDLE: begin
                if (tx_en) begin
                    code = SYM_J;
                    nxt  = FR_SSD2;
                end
            end
            FR_SSD2: begin
                code = SYM_K;
                nxt  = FR_DATA;
            end
            FR_DATA: begin
                if (tx_en) begin
                    code = enc_nib(txd);
                end else begin
                    code = SYM_T;
                    nxt  = FR_ESD2;
                end
            end
            FR_ESD2: begin
                code = SYM_R;
                nxt  = FR_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/fx_serializer.sv
module fx_serializer #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] par,
    output logic         ser,
    output logic         slot
);

    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [CW-1:0] cnt;
    logic [W-1:0]  sreg;

    assign slot = (cnt == LAST);
    assign ser  = sreg[W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            sreg <= '1;
        end else if (slot) begin
            cnt  <= '0;
            sreg <= par;
        end else begin
            cnt  <= cnt + 1'b1;
            sreg <= {sreg[W-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/fx_scrambler.sv
module fx_scrambler #(
    parameter int           W    = 11,
    parameter int           TAP  = 8,
    parameter logic [W-1:0] SEED = {W{1'b1}}
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [W-1:0] s;
    logic         key;

    assign key  = s[W-1] ^ s[TAP];
    assign dout = din ^ key;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s <= SEED;
        else
            s <= {s[W-2:0], key};
    end

endmodule

// File: rtl/fx_mlt3.sv
module fx_mlt3
    import fx_line_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    output logic pos,
    output logic neg
);

    lvl_st_t st, nxt;

    always_comb begin
        nxt = st;
        if (bit_in) begin
            unique case (st)
                LV_ZUP: nxt = LV_POS;
                LV_POS: nxt = LV_ZDN;
                LV_ZDN: nxt = LV_NEG;
                LV_NEG: nxt = LV_ZUP;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st <= LV_ZUP;
        else
            st <= nxt;
    end

    always_comb begin
        pos = (st == LV_POS);
        neg = (st == LV_NEG);
    end

endmodule

// File: rtl/fx_line_enc.sv
module fx_line_enc
    import fx_line_pkg::*;
#(
    parameter int                LFSR_W    = 11,
    parameter int                LFSR_TAP  = 8,
    parameter logic [LFSR_W-1:0] LFSR_SEED = {LFSR_W{1'b1}}
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_en,
    input  logic [3:0] txd,
    output logic       nib_take,
    output logic       line_pos,
    output logic       line_neg
);

    sym_t sym_code;
    logic slot;
    logic ser_bit;
    logic scr_bit;

    assign nib_take = slot;

    fx_sym_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .slot  (slot),
        .tx_en (tx_en),
        .txd   (txd),
        .code  (sym_code)
    );

    fx_serializer #(.W(SYM_W)) u_ser (
        .clk   (clk),
        .rst_n (rst_n),
        .par   (sym_code),
        .ser   (ser_bit),
        .slot  (slot)
    );

    fx_scrambler #(.W(LFSR_W), .TAP(LFSR_TAP), .SEED(LFSR_SEED)) u_scr (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ser_bit),
        .dout  (scr_bit)
    );

    fx_mlt3 u_mlt (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_in (scr_bit),
        .pos    (line_pos),
        .neg    (line_neg)
    );

endmodule

// File: rtl/fx_line_enc_chk.sv
module fx_line_enc_chk
    import fx_line_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic nib_take,
    input logic line_pos,
    input logic line_neg,
    input sym_t code
);

    sym_t       prev_code;
    logic [2:0] gap;
    logic       last_pos;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_code <= SYM_IDLE;
            gap       <= '0;
            last_pos  <= 1'b0;
        end else begin
            if (nib_take) begin
                prev_code <= code;
                gap       <= '0;
            end else begin
                gap <= gap + 1'b1;
            end
            if (line_pos)
                last_pos <= 1'b1;
            else if (line_neg)
                last_pos <= 1'b0;
        end
    end

    // R9
    lvl_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({line_pos, line_neg}));

    // R8
    no_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((line_pos && $past(line_neg)) || (line_neg && $past(line_pos))));

    // R8
    pos_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_pos) |-> !last_pos);

    // R8
    neg_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_neg) |-> last_pos);

    // R6
    take_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nib_take |-> (gap == 3'(SYM_W - 1)));

    // R3
    jk_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nib_take && prev_code == SYM_J) |-> (code == SYM_K));

    // R5
    tr_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nib_take && prev_code == SYM_T) |-> (code == SYM_R));

    // R5
    after_r_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nib_take && prev_code == SYM_R) |-> (code == SYM_IDLE || code == SYM_J));

endmodule

bind fx_line_enc fx_line_enc_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .nib_take (nib_take),
    .line_pos (line_pos),
    .line_neg (line_neg),
    .code     (sym_code)
);

// File: tb/fx_line_enc_tb.sv
module fx_line_enc_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tx_en;
    logic [3:0] txd;
    logic       nib_take;
    logic       line_pos;
    logic       line_neg;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    fx_line_enc u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_en    (tx_en),
        .txd      (txd),
        .nib_take (nib_take),
        .line_pos (line_pos),
        .line_neg (line_neg)
    );

    // receiver model state
    int         prev_lvl, last_nz, sync_n, mode, bitc;
    int         mlt_err = 0, idle_zero = 0, bad_code = 0, bad_r = 0, frames_done = 0;
    int         raw_bits = 0, raw_ones = 0, rx_cnt = 0;
    logic [10:0] dsr;
    logic [9:0]  win;
    logic [4:0]  grp;
    logic [3:0]  tx_buf [0:63];
    logic [3:0]  rx_buf [0:63];

    function automatic logic [4:0] dec5(input logic [4:0] g);
        case (g)
            5'b11110: return 5'h10;
            5'b01001: return 5'h11;
            5'b10100: return 5'h12;
            5'b10101: return 5'h13;
            5'b01010: return 5'h14;
            5'b01011: return 5'h15;
            5'b01110: return 5'h16;
            5'b01111: return 5'h17;
            5'b10010: return 5'h18;
            5'b10011: return 5'h19;
            5'b10110: return 5'h1A;
            5'b10111: return 5'h1B;
            5'b11010: return 5'h1C;
            5'b11011: return 5'h1D;
            5'b11100: return 5'h1E;
            5'b11101: return 5'h1F;
            default:  return 5'h00;
        endcase
    endfunction

    always @(negedge clk) begin
        int   lvl;
        logic rb, key, pb;
        logic [4:0] d;
        if (!rst_n) begin
            prev_lvl = 0; last_nz = -1; sync_n = 0; mode = 0; bitc = 0;
            dsr = '0; win = '0; grp = '0;
        end else begin
            lvl = line_pos ? 1 : (line_neg ? -1 : 0);
            if (line_pos && line_neg) mlt_err++;
            if (prev_lvl != 0 && lvl != 0 && lvl != prev_lvl) mlt_err++;
            if (prev_lvl == 0 && lvl != 0) begin
                if (lvl == last_nz) mlt_err++;
                last_nz = lvl;
            end
            rb = (lvl != prev_lvl);
            raw_bits++;
            if (rb) raw_ones++;
            prev_lvl = lvl;
            if (sync_n < 11) begin
                dsr = {dsr[9:0], rb ^ 1'b1};
                sync_n++;
            end else begin
                key = dsr[10] ^ dsr[8];
                pb  = rb ^ key;
                dsr = {dsr[9:0], key};
                win = {win[8:0], pb};
                if (mode == 0) begin
                    if (!pb) idle_zero++;
                    if (win == 10'b1100010001) begin
                        mode = 1; bitc = 0; rx_cnt = 0;
                    end
                end else begin
                    grp = {grp[3:0], pb};
                    bitc++;
                    if (bitc == 5) begin
                        bitc = 0;
                        if (mode == 1) begin
                            if (grp == 5'b01101) mode = 2;
                            else begin
                                d = dec5(grp);
                                if (d[4] && rx_cnt < 64) begin
                                    rx_buf[rx_cnt] = d[3:0];
                                    rx_cnt++;
                                end else bad_code++;
                            end
                        end else begin
                            if (grp != 5'b00111) bad_r++;
                            frames_done++;
                            mode = 0;
                            win = '0;
                        end
                    end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic test_reset();
        rst_n = 1'b0; tx_en = 1'b0; txd = 4'h0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(line_pos == 1'b0, "R1 pos in reset", int'(line_pos), 0);
        chk(line_neg == 1'b0, "R1 neg in reset", int'(line_neg), 0);
        chk(nib_take == 1'b0, "R1 take in reset", int'(nib_take), 0);
        #1 rst_n = 1'b1;
        repeat (80) @(negedge clk);
        chk(raw_ones > 0, "R1 line active after reset", raw_ones, 1);
    endtask

    task automatic test_take_spacing();
        int n;
        @(negedge clk);
        while (!nib_take) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            n = 0;
            do begin
                @(negedge clk);
                n++;
            end while (!nib_take && n < 20);
            chk(n == 5, "R6 take spacing", n, 5);
        end
    endtask

    task automatic test_idle();
        int z0, b0, o0, bits, ones;
        z0 = idle_zero; b0 = raw_bits; o0 = raw_ones;
        repeat (400) @(negedge clk);
        bits = raw_bits - b0;
        ones = raw_ones - o0;
        chk(idle_zero == z0, "R2 idle descrambles to ones", idle_zero - z0, 0);
        chk(ones > bits / 4 && ones < bits, "R7 scrambled idle toggles", ones, bits / 2);
    endtask

    task automatic send_frame(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            while (!nib_take) @(negedge clk);
            tx_en = 1'b1;
            txd   = tx_buf[i];
        end
        @(negedge clk);
        while (!nib_take) @(negedge clk);
        tx_en = 1'b0;
        txd   = 4'h0;
    endtask

    task automatic run_frame(input int n, input string tag);
        int f0, c0, r0, mism, w;
        f0 = frames_done; c0 = bad_code; r0 = bad_r;
        send_frame(n);
        w = 0;
        while (frames_done == f0 && w < 400) begin
            @(negedge clk);
            w++;
        end
        chk(frames_done == f0 + 1, {"R3 R5 frame closed ", tag}, frames_done - f0, 1);
        chk(rx_cnt == n - 2, {"R3 payload length ", tag}, rx_cnt, n - 2);
        mism = 0;
        for (int i = 2; i < n; i++)
            if (i - 2 < rx_cnt && rx_buf[i-2] != tx_buf[i]) mism++;
        chk(mism == 0, {"R4 payload nibbles ", tag}, mism, 0);
        chk(bad_code == c0, {"R4 legal groups ", tag}, bad_code - c0, 0);
        chk(bad_r == r0, {"R5 T then R ", tag}, bad_r - r0, 0);
        repeat (30) @(negedge clk);
    endtask

    task automatic test_random_frames();
        int lens [3] = '{12, 31, 60};
        for (int f = 0; f < 3; f++) begin
            tx_buf[0] = 4'h5; tx_buf[1] = 4'h5;
            for (int i = 2; i < lens[f]; i++) tx_buf[i] = 4'($urandom_range(0, 15));
            run_frame(lens[f], $sformatf("random%0d", f));
        end
    endtask

    task automatic test_all_values();
        tx_buf[0] = 4'h5; tx_buf[1] = 4'h5;
        for (int i = 0; i < 16; i++) tx_buf[i+2] = 4'(i);
        run_frame(18, "all16");
    endtask

    task automatic test_empty_frame();
        tx_buf[0] = 4'h5; tx_buf[1] = 4'hD;
        run_frame(2, "empty");
    endtask

    task automatic test_line_rules();
        chk(mlt_err == 0, "R8 R9 line level rules", mlt_err, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        test_reset();
        test_take_spacing();
        test_idle();
        test_random_frames();
        test_all_values();
        test_empty_frame();
        test_idle();
        test_line_rules();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule